// File: doc/BRIEF.md
# Sixteen-Bit Counter/Timer with Byte-Wide Preload

This block is a down-counter with two modes and a byte-wide register interface. In counter mode it runs a single countdown from a preload value. It raises a ready flag and drives its waveform output low when the count expires. It keeps decrementing, wrapping through 0xFFFF, until a stop command freezes it. In timer mode it runs freely. It reloads the preload value each time the count expires, toggles the waveform output and sets the ready flag, so the output is a square wave whose half-period lasts as many count-enable pulses as the preload value holds.

Software loads the preload value one byte at a time. Start and stop are not written. They are issued by reading two command addresses, and those reads return zero. In counter mode the running count can be read back one byte at a time. A single-cycle count-enable input stands for the external clock source. The ready flag feeds the interrupt status logic. The waveform output feeds an output pin selector.

Top module: `ctmr_core`

## Requirements
- R1: A synchronous reset leaves the block stopped, with `wave_out` high, `ready` low and `rdata` equal to 0x00.
- R2: A write to address 0 stores the upper preload byte, and a write to address 1 stores the lower preload byte. A read of address 4 is the start command. In the next cycle the count equals the preload value, `wave_out` is high and `ready` is low.
- R3: With `mode_timer` = 0, a read of address 2 returns the upper count byte and a read of address 3 returns the lower count byte. After start with preload P ≥ 1, the P-th `cnt_en` pulse sets `ready` and drives `wave_out` low. Later pulses keep decrementing, so the count wraps from 0x0000 to 0xFFFF.
- R4: With `mode_timer` = 0, a preload write made while counting leaves the running count unchanged. The new value is loaded only by the next start command.
- R5: With `mode_timer` = 0, a read of address 5 is the stop command. It freezes the count, clears `ready` and drives `wave_out` high, and later `cnt_en` pulses leave the frozen count unchanged.
- R6: With `mode_timer` = 1, after start with preload P ≥ 1, every P-th `cnt_en` pulse reloads the count with P, toggles `wave_out` and sets `ready`.
- R7: With `mode_timer` = 1, a preload change made mid-half-period leaves that half-period at its old length. The new value governs the following half-period.
- R8: With `mode_timer` = 1, the stop command only clears `ready`. Counting continues, `wave_out` keeps its level, and the next expiry sets `ready` again.
- R9: With `mode_timer` = 1, reads of the count addresses 2 and 3 return 0x00.
- R10: A start or stop command given in the same cycle as a `cnt_en` pulse takes effect, and that pulse is ignored. In timer mode a preload of 0 or 1 gives a half-period of one pulse.
- R11: `rdata` is registered and shows the read result in the cycle after `rd_en`. Reads of addresses 0, 1, 4, 5, 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_timer | input | 1 | 1 selects timer mode, 0 selects counter mode |
| cnt_en | input | 1 | Single-cycle count enable pulse |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (also issues commands) |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Registered read data byte |
| ready | output | 1 | Counter ready status flag |
| wave_out | output | 1 | Counter/timer waveform output |

## Verification
The assertions sample `mode_timer` in the cycle of a command or read and relate that to the next cycle's outputs. They assume the mode does not change between a command and the following edge. The stimulus changes the mode only while the counter is stopped and no command or read is in flight. It also never issues a read and a write in the same cycle. Counter-mode count reads are made while counting pauses, as software must do, so the expected byte is exact.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int unsigned BYTE_W = 8;

  typedef struct packed {
    logic start;
    logic stop;
  } ctmr_cmd_t;
endpackage

// File: rtl/ctmr_regs.sv
module ctmr_regs import ctmr_pkg::*; #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  output logic [CNT_W-1:0]  preload,
  output ctmr_cmd_t         cmd
);
  localparam int unsigned NB = CNT_W / BYTE_W;
  localparam logic [ADDR_W-1:0] START_A = ADDR_W'(2*NB);
  localparam logic [ADDR_W-1:0] STOP_A  = ADDR_W'(2*NB+1);

  // Preload byte k (k = 0 is least significant) sits at address NB-1-k.
  for (genvar k = 0; k < NB; k++) begin : g_pre
    localparam logic [ADDR_W-1:0] BYTE_A = ADDR_W'(NB-1-k);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (rst) begin
        q <= '0;
      end else if (wr_en && addr == BYTE_A) begin
        q <= wdata;
      end
    end
    assign preload[k*BYTE_W +: BYTE_W] = q;
  end

  assign cmd.start = rd_en && (addr == START_A);
  assign cmd.stop  = rd_en && (addr == STOP_A);
endmodule

// File: rtl/ctmr_engine.sv
module ctmr_engine import ctmr_pkg::*; #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tmode,
  input  logic             cnt_en,
  input  ctmr_cmd_t        cmd,
  input  logic [CNT_W-1:0] preload,
  output logic [CNT_W-1:0] count,
  output logic             ready,
  output logic             wave_out
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic running;
  logic expire;

  // Timer mode treats 0 like 1 so a zero preload still toggles every pulse.
  assign expire = tmode ? (count <= ONE) : (count == ONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      count    <= '0;
      running  <= 1'b0;
      ready    <= 1'b0;
      wave_out <= 1'b1;
    end else if (cmd.start) begin
      count    <= preload;
      running  <= 1'b1;
      ready    <= 1'b0;
      wave_out <= 1'b1;
    end else if (cmd.stop) begin
      ready <= 1'b0;
      if (!tmode) begin
        running  <= 1'b0;
        wave_out <= 1'b1;
      end
    end else if (cnt_en && running) begin
      if (tmode) begin
        if (expire) begin
          count    <= preload;
          wave_out <= ~wave_out;
          ready    <= 1'b1;
        end else begin
          count <= count - ONE;
        end
      end else begin
        count <= count - ONE;
        if (expire) begin
          ready    <= 1'b1;
          wave_out <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/ctmr_rdback.sv
module ctmr_rdback import ctmr_pkg::*; #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tmode,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [CNT_W-1:0]  count,
  output logic [BYTE_W-1:0] rdata
);
  localparam int unsigned NB = CNT_W / BYTE_W;

  logic [BYTE_W-1:0] sel;

  // Count byte k is visible at address 2*NB-1-k, counter mode only.
  always_comb begin
    sel = '0;
    for (int k = 0; k < NB; k++) begin
      if (!tmode && addr == ADDR_W'(2*NB-1-k)) begin
        sel = count[k*BYTE_W +: BYTE_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= sel;
    end
  end
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core import ctmr_pkg::*; #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_timer,
  input  logic              cnt_en,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              ready,
  output logic              wave_out
);
  logic [CNT_W-1:0] preload;
  logic [CNT_W-1:0] count;
  ctmr_cmd_t        cmd;
  logic             start_cmd;
  logic             stop_cmd;

  assign start_cmd = cmd.start;
  assign stop_cmd  = cmd.stop;

  ctmr_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .preload(preload), .cmd(cmd)
  );

  ctmr_engine #(.CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst(rst), .tmode(mode_timer), .cnt_en(cnt_en), .cmd(cmd),
    .preload(preload), .count(count), .ready(ready), .wave_out(wave_out)
  );

  ctmr_rdback #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_rdback (
    .clk(clk), .rst(rst), .tmode(mode_timer), .rd_en(rd_en), .addr(addr),
    .count(count), .rdata(rdata)
  );
endmodule

// File: rtl/ctmr_chk.sv
module ctmr_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              tmode,
  input logic              cnt_en,
  input logic              start_cmd,
  input logic              stop_cmd,
  input logic              rd_en,
  input logic [ADDR_W-1:0] addr,
  input logic [7:0]        rdata,
  input logic              ready,
  input logic              wave_out
);
  localparam int unsigned NB = CNT_W / 8;

  logic cnt_rd;
  assign cnt_rd = rd_en && (addr >= ADDR_W'(NB)) && (addr < ADDR_W'(2*NB));

  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (wave_out && !ready)); // R1
  AST_START_RESETS_OUT: assert property (@(posedge clk) disable iff (rst)
    start_cmd |=> (wave_out && !ready)); // R2
  AST_READY_RISE_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $rose(ready) |-> $past(cnt_en)); // R3
  AST_CNT_STOP_OUT: assert property (@(posedge clk) disable iff (rst)
    (stop_cmd && !tmode) |=> (wave_out && !ready)); // R5
  AST_TMR_STOP_HOLDS_WAVE: assert property (@(posedge clk) disable iff (rst)
    (stop_cmd && tmode) |=> ($stable(wave_out) && !ready)); // R8
  AST_TMR_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (cnt_rd && tmode) |=> (rdata == 8'h00)); // R9
  AST_WAVE_FALL_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    $fell(wave_out) |-> ($past(cnt_en) && !$past(start_cmd) && !$past(stop_cmd))); // R10
endmodule

bind ctmr_core ctmr_chk #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_chk (
  .clk(clk), .rst(rst), .tmode(mode_timer), .cnt_en(cnt_en),
  .start_cmd(start_cmd), .stop_cmd(stop_cmd), .rd_en(rd_en), .addr(addr),
  .rdata(rdata), .ready(ready), .wave_out(wave_out)
);

// File: tb/test_ctmr_core.sv
`timescale 1ns/1ps
module test_ctmr_core;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mode_timer = 1'b0;
  logic       cnt_en = 1'b0;
  logic       wr_en = 1'b0;
  logic       rd_en = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       ready;
  logic       wave_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #2.5 clk = ~clk;

  ctmr_core i_ctmr_core (
    .clk(clk), .rst(rst), .mode_timer(mode_timer), .cnt_en(cnt_en),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ready(ready), .wave_out(wave_out)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Driver: every read pushes its expected byte to the scoreboard.
  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag, input bit with_tick = 1'b0);
    rd_en = 1'b1; addr = a; cnt_en = with_tick;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    rd_en = 1'b0; cnt_en = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      cnt_en = 1'b1;
      @(negedge clk);
      cnt_en = 1'b0;
    end
  endtask

  task automatic outs(input string tag, input logic w, input logic r);
    chk({tag, " wave"}, {7'd0, wave_out}, {7'd0, w});
    chk({tag, " ready"}, {7'd0, ready}, {7'd0, r});
  endtask

  // Monitor: pops and compares one expected byte per completed read.
  initial begin
    forever begin
      logic was_rd;
      @(posedge clk);
      was_rd = rd_en;
      @(negedge clk);
      if (was_rd) begin
        if (exp_q.size() == 0) begin
          chk("scoreboard underflow", 8'h01, 8'h00);
        end else begin
          chk(tag_q.pop_front(), rdata, exp_q.pop_front());
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    outs("R1 reset", 1'b1, 1'b0);
    chk("R1 reset rdata", rdata, 8'h00);

    // Counter mode, preload 0x0005
    wr(3'd0, 8'h00); wr(3'd1, 8'h05);
    rd(3'd4, 8'h00, "R2 start read");
    outs("R2 after start", 1'b1, 1'b0);
    rd(3'd3, 8'h05, "R2 count lo");
    rd(3'd2, 8'h00, "R3 count hi");
    tick(4);
    outs("R3 before terminal", 1'b1, 1'b0);
    wr(3'd1, 8'h09);
    tick(1);
    outs("R4 terminal with old preload", 1'b0, 1'b1);
    tick(1);
    rd(3'd5, 8'h00, "R5 stop read");
    outs("R5 after stop", 1'b1, 1'b0);
    tick(3);
    rd(3'd2, 8'hFF, "R3 wrap hi");
    rd(3'd3, 8'hFF, "R5 frozen lo");
    rd(3'd0, 8'h00, "R11 preload addr");
    rd(3'd6, 8'h00, "R11 unmapped addr");
    rd(3'd4, 8'h00, "R10 start with tick", 1'b1);
    rd(3'd3, 8'h09, "R10 tick ignored on start");
    rd(3'd2, 8'h00, "R4 new preload hi");
    tick(8);
    outs("R4 one before terminal", 1'b1, 1'b0);
    tick(1);
    outs("R3 terminal at 9", 1'b0, 1'b1);
    rd(3'd5, 8'h00, "R5 stop read");
    wr(3'd0, 8'h12); wr(3'd1, 8'h34);
    rd(3'd4, 8'h00, "R2 start read");
    rd(3'd2, 8'h12, "R2 upper byte");
    rd(3'd3, 8'h34, "R2 lower byte");
    rd(3'd5, 8'h00, "R5 stop read");
    @(negedge clk);

    // Timer mode, preload 0x0003
    mode_timer = 1'b1;
    wr(3'd0, 8'h00); wr(3'd1, 8'h03);
    rd(3'd4, 8'h00, "R6 start read");
    tick(2);
    outs("R6 mid half-period", 1'b1, 1'b0);
    tick(1);
    outs("R6 first toggle", 1'b0, 1'b1);
    rd(3'd2, 8'h00, "R9 timer count hi");
    rd(3'd3, 8'h00, "R9 timer count lo");
    rd(3'd5, 8'h00, "R8 stop read");
    outs("R8 after stop", 1'b0, 1'b0);
    tick(3);
    outs("R8 keeps running", 1'b1, 1'b1);
    tick(1);
    wr(3'd1, 8'h02);
    tick(1);
    outs("R7 old half-period continues", 1'b1, 1'b1);
    tick(1);
    outs("R7 old half-period ends", 1'b0, 1'b1);
    tick(1);
    outs("R7 new half-period mid", 1'b0, 1'b1);
    tick(1);
    outs("R7 new half-period ends", 1'b1, 1'b1);

    // Preload 1 and 0 in timer mode
    wr(3'd1, 8'h01);
    rd(3'd4, 8'h00, "R10 start preload 1");
    tick(1);
    outs("R10 preload 1 first", 1'b0, 1'b1);
    tick(1);
    outs("R10 preload 1 second", 1'b1, 1'b1);
    wr(3'd1, 8'h00);
    rd(3'd4, 8'h00, "R10 start preload 0");
    tick(1);
    outs("R10 preload 0", 1'b0, 1'b1);

    repeat (3) @(negedge clk);
    chk("R11 scoreboard drained", 8'(exp_q.size()), 8'h00);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule